// File: doc/BRIEF.md
# Three-State Line Coherence Controller

This block keeps the coherence state of every line of a small direct-indexed cache under a three-state protocol: Invalid, Exclusive and Modified. No shared state exists. A line held by this cache is either clean and owned alone (Exclusive) or dirty (Modified). The block has two ports. The processor port reports local reads and writes. The snoop port reports transactions that other bus agents make. For each one, the block updates the state of the indexed line and raises the bus action that the transition needs: a line fill on a local miss, or a copy-back push when a snoop finds dirty data.

The block does not compare tags or move data. Each port brings a tag-match flag, and the block treats a line as hit only when that flag is set and the stored state is not Invalid. A snoop also carries one attribute bit. The bit tells a cache-inhibited read apart from a cacheable read or write. A cache-inhibited read of a dirty line pushes the data but keeps the line valid as a clean Exclusive copy. Both ports may present a transaction in the same cycle. The snoop is applied first, and the processor request then sees the state the snoop left behind.

Top module: `mei_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid, and fill_req_o, push_req_o, req_done_o and snp_done_o are low.
- R2: A processor read is a miss when req_tag_match_i is low or the line is Invalid. A read miss raises fill_req_o with the request index and leaves the line Exclusive.
- R3: A processor write miss raises fill_req_o with the request index and leaves the line Modified.
- R4: A write hit moves an Exclusive line to Modified and keeps a Modified line Modified, without a fill.
- R5: A read hit leaves an Exclusive or Modified line unchanged, without a fill.
- R6: A snoop hit on an Exclusive line makes it Invalid when snp_inhibit_i is 0 (cacheable read or write). It leaves the line Exclusive when snp_inhibit_i is 1 (cache-inhibited read). It never raises a push.
- R7: A snoop hit on a Modified line raises push_req_o with the snoop index. The line becomes Exclusive when snp_inhibit_i is 1 and Invalid when it is 0.
- R8: A snoop whose tag does not match, or that finds the line Invalid, changes no state and raises no push.
- R9: When both ports name the same index in one cycle, the snoop applies first and the processor request is judged against the post-snoop state.
- R10: Every result appears one clock after the request. req_done_o/snp_done_o pulse, and req_state_o/snp_state_o carry the new state (0 = Invalid, 1 = Exclusive, 2 = Modified). The array holds that state from that clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Processor request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_tag_match_i | input | 1 | Tag comparison matched for the processor request |
| req_index_i | input | IDX_W | Line index of the processor request |
| snp_valid_i | input | 1 | Snooped transaction present |
| snp_inhibit_i | input | 1 | 1 = cache-inhibited read, 0 = cacheable read/write |
| snp_tag_match_i | input | 1 | Tag comparison matched for the snoop |
| snp_index_i | input | IDX_W | Line index of the snoop |
| fill_req_o | output | 1 | Line fill requested |
| fill_index_o | output | IDX_W | Index to fill |
| push_req_o | output | 1 | Copy-back push requested |
| push_index_o | output | IDX_W | Index to push |
| req_done_o | output | 1 | Processor result valid |
| req_state_o | output | 2 | Line state after the processor request |
| snp_done_o | output | 1 | Snoop result valid |
| snp_state_o | output | 2 | Line state after the snoop |

## Verification
Every line is driven into each of the three states through ordinary reads, writes and snoops. From each state it then receives matching and non-matching reads and writes, and cacheable, inhibited and non-matching snoops. This separates hits from misses on valid lines from misses on Invalid ones, and it separates the two snoop attributes on clean and dirty lines. Concurrent snoop and processor transactions are tried on the same index and on different indices. This shows whether the request sees the post-snoop state and whether the two writes to the array stay independent.

// File: rtl/mei_pkg.sv
package mei_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_EXC = 2'd1,
        ST_MOD = 2'd2
    } line_state_t;

    typedef struct packed {
        line_state_t next;
        logic        fill;
    } req_result_t;

    typedef struct packed {
        line_state_t next;
        logic        hit;
        logic        push;
    } snp_result_t;

    function automatic logic is_valid(line_state_t s);
        return s != ST_INV;
    endfunction

endpackage

// File: rtl/mei_state_array.sv
module mei_state_array
    import mei_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output line_state_t       rd_a_state,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output line_state_t       rd_b_state,
    input  logic              wr_a_en,
    input  logic [IDX_W-1:0]  wr_a_idx,
    input  line_state_t       wr_a_state,
    input  logic              wr_b_en,
    input  logic [IDX_W-1:0]  wr_b_idx,
    input  line_state_t       wr_b_state
);
    logic [2*LINES-1:0] flat;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_state_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= ST_INV;
            else if (wr_b_en && wr_b_idx == IDX_W'(i))
                q <= wr_b_state;      // port b wins: it already saw port a's result
            else if (wr_a_en && wr_a_idx == IDX_W'(i))
                q <= wr_a_state;
        end
        assign flat[2*i +: 2] = q;
    end

    assign rd_a_state = line_state_t'(flat[2*rd_a_idx +: 2]);
    assign rd_b_state = line_state_t'(flat[2*rd_b_idx +: 2]);
endmodule

// File: rtl/mei_snoop_eval.sv
module mei_snoop_eval
    import mei_pkg::*;
(
    input  logic         valid,
    input  logic         inhibit,
    input  logic         tag_match,
    input  line_state_t  cur,
    output snp_result_t  res
);
    always_comb begin
        res.hit  = valid && tag_match && is_valid(cur);
        res.push = 1'b0;
        res.next = cur;
        if (res.hit) begin
            unique case (cur)
                ST_EXC: res.next = inhibit ? ST_EXC : ST_INV;
                ST_MOD: begin
                    res.push = 1'b1;
                    res.next = inhibit ? ST_EXC : ST_INV;
                end
                default: res.next = cur;
            endcase
        end
    end
endmodule

// File: rtl/mei_req_eval.sv
module mei_req_eval
    import mei_pkg::*;
(
    input  logic         valid,
    input  logic         write,
    input  logic         tag_match,
    input  line_state_t  cur,
    output req_result_t  res
);
    logic hit;

    always_comb begin
        hit      = tag_match && is_valid(cur);
        res.fill = 1'b0;
        res.next = cur;
        if (valid) begin
            if (!hit) begin
                res.fill = 1'b1;
                res.next = write ? ST_MOD : ST_EXC;
            end else if (write) begin
                res.next = ST_MOD;
            end
        end
    end
endmodule

// File: rtl/mei_coherence_ctrl.sv
module mei_coherence_ctrl
    import mei_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic              req_tag_match_i,
    input  logic [IDX_W-1:0]  req_index_i,
    input  logic              snp_valid_i,
    input  logic              snp_inhibit_i,
    input  logic              snp_tag_match_i,
    input  logic [IDX_W-1:0]  snp_index_i,
    output logic              fill_req_o,
    output logic [IDX_W-1:0]  fill_index_o,
    output logic              push_req_o,
    output logic [IDX_W-1:0]  push_index_o,
    output logic              req_done_o,
    output logic [1:0]        req_state_o,
    output logic              snp_done_o,
    output logic [1:0]        snp_state_o
);
    line_state_t snp_cur, req_stored, req_base;
    snp_result_t snp_res;
    req_result_t req_res;
    logic        same_line;

    mei_state_array #(.LINES(LINES)) u_array (
        .clk        (clk),
        .rst        (rst),
        .rd_a_idx   (snp_index_i),
        .rd_a_state (snp_cur),
        .rd_b_idx   (req_index_i),
        .rd_b_state (req_stored),
        .wr_a_en    (snp_res.hit),
        .wr_a_idx   (snp_index_i),
        .wr_a_state (snp_res.next),
        .wr_b_en    (req_valid_i),
        .wr_b_idx   (req_index_i),
        .wr_b_state (req_res.next)
    );

    mei_snoop_eval u_snoop (
        .valid     (snp_valid_i),
        .inhibit   (snp_inhibit_i),
        .tag_match (snp_tag_match_i),
        .cur       (snp_cur),
        .res       (snp_res)
    );

    // The snoop owns the array first; a request on the same line sees its result.
    assign same_line = snp_res.hit && (snp_index_i == req_index_i);
    assign req_base  = same_line ? snp_res.next : req_stored;

    mei_req_eval u_req (
        .valid     (req_valid_i),
        .write     (req_write_i),
        .tag_match (req_tag_match_i),
        .cur       (req_base),
        .res       (req_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_req_o   <= 1'b0;
            fill_index_o <= '0;
            push_req_o   <= 1'b0;
            push_index_o <= '0;
            req_done_o   <= 1'b0;
            req_state_o  <= ST_INV;
            snp_done_o   <= 1'b0;
            snp_state_o  <= ST_INV;
        end else begin
            fill_req_o   <= req_res.fill;
            fill_index_o <= req_index_i;
            push_req_o   <= snp_res.push;
            push_index_o <= snp_index_i;
            req_done_o   <= req_valid_i;
            req_state_o  <= req_res.next;
            snp_done_o   <= snp_valid_i;
            snp_state_o  <= snp_res.next;
        end
    end
endmodule

// File: rtl/mei_coherence_checker.sv
module mei_coherence_checker #(
    parameter int IDX_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid_i,
    input logic              req_write_i,
    input logic              req_tag_match_i,
    input logic [IDX_W-1:0]  req_index_i,
    input logic              snp_valid_i,
    input logic              snp_inhibit_i,
    input logic              snp_tag_match_i,
    input logic [IDX_W-1:0]  snp_index_i,
    input logic              fill_req_o,
    input logic [IDX_W-1:0]  fill_index_o,
    input logic              push_req_o,
    input logic [IDX_W-1:0]  push_index_o,
    input logic              req_done_o,
    input logic [1:0]        req_state_o,
    input logic              snp_done_o,
    input logic [1:0]        snp_state_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!fill_req_o && !push_req_o));

    assert_fill_from_request_R2: assert property (@(posedge clk) disable iff (rst)
        fill_req_o |-> (req_done_o && $past(req_valid_i) && fill_index_o == $past(req_index_i)));

    assert_write_ends_modified_R3: assert property (@(posedge clk) disable iff (rst)
        (req_done_o && $past(req_write_i)) |-> req_state_o == 2'd2);

    assert_read_ends_valid_R5: assert property (@(posedge clk) disable iff (rst)
        (req_done_o && !$past(req_write_i)) |-> (req_state_o == 2'd1 || req_state_o == 2'd2));

    assert_push_from_snoop_R7: assert property (@(posedge clk) disable iff (rst)
        push_req_o |-> (snp_done_o && push_index_o == $past(snp_index_i)));

    assert_inhibited_push_keeps_line_R7: assert property (@(posedge clk) disable iff (rst)
        (push_req_o && $past(snp_inhibit_i)) |-> snp_state_o == 2'd1);

    assert_no_push_on_mismatch_R8: assert property (@(posedge clk) disable iff (rst)
        push_req_o |-> $past(snp_tag_match_i));

    assert_snoop_never_dirties_R6: assert property (@(posedge clk) disable iff (rst)
        snp_done_o |-> snp_state_o != 2'd2 || !push_req_o);
endmodule

bind mei_coherence_ctrl mei_coherence_checker #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_mei_coherence_ctrl.sv
module tb_mei_coherence_ctrl;
    localparam int LINES = 8;
    localparam int IW    = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid_i = 0, req_write_i = 0, req_tag_match_i = 0;
    logic [IW-1:0] req_index_i = '0;
    logic          snp_valid_i = 0, snp_inhibit_i = 0, snp_tag_match_i = 0;
    logic [IW-1:0] snp_index_i = '0;
    logic          fill_req_o, push_req_o, req_done_o, snp_done_o;
    logic [IW-1:0] fill_index_o, push_index_o;
    logic [1:0]    req_state_o, snp_state_o;

    int compared = 0, mismatched = 0;
    int model [LINES];

    always #2 clk = ~clk;   // 250 MHz

    mei_coherence_ctrl #(.LINES(LINES)) dut (.*);

    task automatic chk(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One transaction cycle; expected values come from the protocol table.
    task automatic run(bit rv, bit rw, bit rm, int ri, bit sv, bit si, bit sm, int sidx);
        int    s_next, r_base, r_next;
        bit    s_hit, push, fill, r_hit;
        string stag, rtag;
        s_next = model[sidx]; push = 0; stag = "R8";
        s_hit = sv && sm && model[sidx] != 0;
        if (s_hit) begin
            if (model[sidx] == 2) begin push = 1; stag = "R7"; end
            else stag = "R6";
            s_next = si ? 1 : 0;
        end
        r_base = (s_hit && sidx == ri) ? s_next : model[ri];
        r_hit  = rm && r_base != 0;
        fill   = rv && !r_hit;
        r_next = r_base;
        if (rv) r_next = rw ? 2 : (r_hit ? r_base : 1);
        rtag = fill ? (rw ? "R3" : "R2") : (rw ? "R4" : "R5");
        if (rv && s_hit && sidx == ri) rtag = "R9";

        req_valid_i = rv; req_write_i = rw; req_tag_match_i = rm; req_index_i = IW'(ri);
        snp_valid_i = sv; snp_inhibit_i = si; snp_tag_match_i = sm; snp_index_i = IW'(sidx);
        @(negedge clk);
        // R10: results appear one clock after the request
        chk(rtag, "req_done", int'(req_done_o), int'(rv));
        chk(rtag, "fill_req", int'(fill_req_o), int'(fill));
        if (fill) chk(rtag, "fill_index", int'(fill_index_o), ri);
        if (rv) chk(rtag, "req_state", int'(req_state_o), r_next);
        chk(stag, "snp_done", int'(snp_done_o), int'(sv));
        chk(stag, "push_req", int'(push_req_o), int'(push));
        if (push) chk(stag, "push_index", int'(push_index_o), sidx);
        if (sv) chk(stag, "snp_state", int'(snp_state_o), s_next);
        if (s_hit) model[sidx] = s_next;
        if (rv) model[ri] = r_next;
        req_valid_i = 0; snp_valid_i = 0;
    endtask

    task automatic force_state(int idx, int s);
        if (s == 0) run(0, 0, 0, 0, 1, 0, 1, idx);       // cacheable snoop clears it
        else run(1, s == 2, 0, idx, 0, 0, 0, 0);         // miss fills to E or M
        if (s == 0 && model[idx] != 0) run(0, 0, 0, 0, 1, 0, 1, idx);
    endtask

    initial begin
        for (int i = 0; i < LINES; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        chk("R1", "fill_req in reset", int'(fill_req_o), 0);
        chk("R1", "push_req in reset", int'(push_req_o), 0);
        chk("R1", "req_done in reset", int'(req_done_o), 0);
        chk("R1", "snp_done in reset", int'(snp_done_o), 0);
        rst = 1'b0;
        // R1: every line starts Invalid, so a matching snoop pushes nothing and a matching read fills
        for (int i = 0; i < LINES; i++) run(0, 0, 0, 0, 1, 0, 1, i);
        for (int i = 0; i < LINES; i++) run(1, 0, 1, i, 0, 0, 0, 0);
        // single-port sweep: every line, start state and operation
        for (int i = 0; i < LINES; i++)
            for (int s = 0; s < 3; s++)
                for (int op = 0; op < 7; op++) begin
                    force_state(i, s);
                    chk("R10", "model setup", model[i], s);
                    case (op)
                        0: run(1, 0, 1, i, 0, 0, 0, 0);
                        1: run(1, 0, 0, i, 0, 0, 0, 0);
                        2: run(1, 1, 1, i, 0, 0, 0, 0);
                        3: run(1, 1, 0, i, 0, 0, 0, 0);
                        4: run(0, 0, 0, 0, 1, 0, 1, i);
                        5: run(0, 0, 0, 0, 1, 1, 1, i);
                        default: run(0, 0, 0, 0, 1, 0, 0, i);
                    endcase
                    // R10: state held in the array; a non-matching snoop reads it back untouched
                    run(0, 0, 0, 0, 1, 0, 0, i);
                end
        // R9: concurrent ports, same and different lines
        for (int s = 0; s < 3; s++)
            for (int t = 0; t < 3; t++)
                for (int k = 0; k < 16; k++) begin
                    force_state(2, s);
                    force_state(5, t);
                    run(1, k[0], k[1], (k[3] ? 5 : 2), 1, k[2], 1, 2);
                    run(0, 0, 0, 0, 1, 0, 0, 2);
                    run(0, 0, 0, 0, 1, 0, 0, 5);
                end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule